// File: doc/BRIEF.md
# Dual-Mode Synthesizer Feedback Divider

This block is the feedback divider of a frequency synthesizer. It counts cycles of a local-oscillator input and emits one pulse each time a programmed modulus N has been reached. The pulse goes on to a phase comparator outside the block. Two oscillator inputs are provided, one for the AM band and one for the FM band, and a band bit picks between them. For the AM input a structure bit selects one of two counting structures. The first is a pulse-swallow divider, made of a 16/17 dual-modulus stage with a 4-bit swallow counter and a 12-bit main counter, giving N = 16·P + S. The second is a plain 12-bit programmable down-counter. The FM input always goes through a fixed divide-by-2 stage and then the pulse-swallow divider, so the FM ratio is twice the programmed value.

The block runs on a single system clock `clk_i`. Each oscillator input is a strobe that is high for one clock for every oscillator cycle, already edge-detected upstream. The modulus arrives on a parallel bus and may change at any time. A new value is taken only when the current output cycle ends. Any change of the active counting path clears the counters synchronously and starts a fresh cycle.

Top module: `dual_mode_divider`

## Requirements
- R1: With `band_i`=0 only `am_lo_i` strobes are counted, and with `band_i`=1 only `fm_lo_i` strobes are counted; strobes on the other input never advance the count and never cause a pulse.
- R2: With `band_i`=0 and `swallow_i`=1, the pulse-swallow path is used and one pulse occurs per `mod_i` strobes for `mod_i` from 256 to 65535.
- R3: With `band_i`=0 and `swallow_i`=0, the direct divider is used. It reads only `mod_i[11:0]`, and one pulse occurs per `mod_i[11:0]` strobes for values from 4 to 4095.
- R4: With `band_i`=1, one pulse occurs per 2·`mod_i` FM strobes for `mod_i` from 256 to 65535.
- R5: A programmed value of 0 stands for the top of the range: 65536 on the swallow paths and 4096 on the direct path.
- R6: Nonzero values below the minimum are raised to it: 256 on the swallow paths and 4 on the direct path.
- R7: A change of `mod_i` during an output cycle leaves that cycle's length unchanged and applies from the next cycle.
- R8: `pulse_o` is high for exactly one clock. It rises in the clock after the clock in which the strobe that completes the cycle was present.
- R9: A change of the active path clears all counters, including the divide-by-2 stage. The active path is direct, AM swallow or FM, and the FM path applies whenever `band_i`=1. The clock after the change carries no pulse, strobes present in the change clock are ignored, and the first full cycle then takes N strobes. The same restart occurs on the first clock after reset.
- R10: While `band_i`=1 the value of `swallow_i` has no effect, and toggling it does not disturb the running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| am_lo_i | input | 1 | AM oscillator cycle strobe |
| fm_lo_i | input | 1 | FM oscillator cycle strobe |
| band_i | input | 1 | 0 = AM input, 1 = FM input |
| swallow_i | input | 1 | AM structure: 1 = pulse-swallow, 0 = direct 12-bit |
| mod_i | input | 16 | Programmed modulus |
| pulse_o | output | 1 | One-clock pulse per completed division cycle |

## Verification
Four properties are checked on every cycle:
- the pulse lasts one clock;
- every pulse follows a strobe of the selected input;
- the clock after a path change stays quiet;
- the strobes counted since the previous pulse are never fewer than the minimum ratio of the active path.

The exact ratio of each path, the encoding of 0 as the top of the range, the raising of small values, the timing of a modulus update and the first-cycle length after a restart can only be shown by the bench. It does this by counting strobes between pulses over sweeps of moduli and by switching modes mid-cycle.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int SWAL_W_DEF = 4;
  localparam int MAIN_W_DEF = 12;
  localparam int DIR_W_DEF  = 12;

  typedef enum logic [1:0] {
    PATH_DIRECT  = 2'd0,
    PATH_AM_SWAL = 2'd1,
    PATH_FM_SWAL = 2'd2
  } path_e;
endpackage

// File: rtl/dmd_modcalc.sv
// Turns the programmed value into counter reload values for both structures.
module dmd_modcalc #(
  parameter int SWAL_W = 4,
  parameter int MAIN_W = 12,
  parameter int DIR_W  = 12,
  localparam int MOD_W = SWAL_W + MAIN_W
) (
  input  logic [MOD_W-1:0]  mod_i,
  output logic [MAIN_W-1:0] main_ld_o,
  output logic [SWAL_W-1:0] swal_ld_o,
  output logic [DIR_W-1:0]  dir_ld_o
);
  localparam logic [MOD_W:0] SW_MIN  = (MOD_W+1)'(1) << (2*SWAL_W);
  localparam logic [MOD_W:0] SW_TOP  = (MOD_W+1)'(1) << MOD_W;
  localparam logic [DIR_W:0] DIR_MIN = (DIR_W+1)'(4);
  localparam logic [DIR_W:0] DIR_TOP = (DIR_W+1)'(1) << DIR_W;

  logic [MOD_W:0] sw_n, p_m1;
  logic [DIR_W:0] d_n, d_m1;
  logic [DIR_W-1:0] d_raw;

  assign d_raw = mod_i[DIR_W-1:0];

  always_comb begin
    if (mod_i == '0)                sw_n = SW_TOP;
    else if ({1'b0, mod_i} < SW_MIN) sw_n = SW_MIN;
    else                            sw_n = {1'b0, mod_i};
    p_m1 = (sw_n >> SWAL_W) - (MOD_W+1)'(1);
  end

  always_comb begin
    if (d_raw == '0)                 d_n = DIR_TOP;
    else if ({1'b0, d_raw} < DIR_MIN) d_n = DIR_MIN;
    else                             d_n = {1'b0, d_raw};
    d_m1 = d_n - (DIR_W+1)'(1);
  end

  assign main_ld_o = p_m1[MAIN_W-1:0];
  assign swal_ld_o = sw_n[SWAL_W-1:0];
  assign dir_ld_o  = d_m1[DIR_W-1:0];
endmodule

// File: rtl/dmd_prescale2.sv
// Fixed divide-by-2: passes every second input strobe.
module dmd_prescale2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic stb_i,
  output logic stb_o
);
  logic t_q;

  assign stb_o = stb_i && t_q && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    t_q <= 1'b0;
    else if (clr_i) t_q <= 1'b0;
    else if (stb_i) t_q <= ~t_q;
  end
endmodule

// File: rtl/dmd_swallow.sv
// Dual-modulus (2^SW / 2^SW+1) stage with swallow and main counters.
module dmd_swallow #(
  parameter int SWAL_W = 4,
  parameter int MAIN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              stb_i,
  input  logic [MAIN_W-1:0] main_ld_i,
  input  logic [SWAL_W-1:0] swal_ld_i,
  output logic              done_o
);
  localparam int PW = SWAL_W + 1;
  localparam logic [PW-1:0] LAST_LO = PW'((1 << SWAL_W) - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(1 << SWAL_W);

  logic [PW-1:0]     pre_q;
  logic [SWAL_W-1:0] swal_q;
  logic [MAIN_W-1:0] main_q;
  logic              tick, main_end;
  logic [PW-1:0]     pre_last;

  // extra count per prescaler cycle while swallow count remains
  assign pre_last = (swal_q != '0) ? LAST_HI : LAST_LO;
  assign tick     = stb_i && (pre_q == pre_last);
  assign main_end = (main_q == '0);
  assign done_o   = tick && main_end && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      swal_q <= '0;
      main_q <= '0;
    end else if (load_i) begin
      pre_q  <= '0;
      swal_q <= swal_ld_i;
      main_q <= main_ld_i;
    end else if (stb_i) begin
      if (tick) begin
        pre_q <= '0;
        if (main_end) begin
          main_q <= main_ld_i;
          swal_q <= swal_ld_i;
        end else begin
          main_q <= main_q - 1'b1;
          if (swal_q != '0) swal_q <= swal_q - 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmd_direct.sv
// Plain programmable down-counter.
module dmd_direct #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         stb_i,
  input  logic [W-1:0] ld_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = (cnt_q == '0);
  assign done_o = stb_i && last && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= ld_i;
    else if (stb_i)  cnt_q <= last ? ld_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/dual_mode_divider.sv
module dual_mode_divider
  import dmd_pkg::*;
#(
  parameter int SWAL_W = SWAL_W_DEF,
  parameter int MAIN_W = MAIN_W_DEF,
  parameter int DIR_W  = DIR_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     am_lo_i,
  input  logic                     fm_lo_i,
  input  logic                     band_i,
  input  logic                     swallow_i,
  input  logic [SWAL_W+MAIN_W-1:0] mod_i,
  output logic                     pulse_o
);
  localparam int MOD_W = SWAL_W + MAIN_W;

  path_e path_d, path_q;
  logic  init_q, restart;
  logic  fm_half, swal_stb, dir_stb;
  logic  swal_done, dir_done;
  logic [MAIN_W-1:0] main_ld;
  logic [SWAL_W-1:0] swal_ld;
  logic [DIR_W-1:0]  dir_ld;

  always_comb begin
    if (band_i)         path_d = PATH_FM_SWAL;
    else if (swallow_i) path_d = PATH_AM_SWAL;
    else                path_d = PATH_DIRECT;
  end

  assign restart = init_q || (path_d != path_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      path_q <= PATH_DIRECT;
    end else begin
      init_q <= 1'b0;
      path_q <= path_d;
    end
  end

  dmd_modcalc #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .DIR_W(DIR_W)) u_modcalc (
    .mod_i     (mod_i[MOD_W-1:0]),
    .main_ld_o (main_ld),
    .swal_ld_o (swal_ld),
    .dir_ld_o  (dir_ld)
  );

  dmd_prescale2 u_pre2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .stb_i  (fm_lo_i && band_i),
    .stb_o  (fm_half)
  );

  always_comb begin
    swal_stb = 1'b0;
    dir_stb  = 1'b0;
    if (!restart) begin
      unique case (path_d)
        PATH_FM_SWAL: swal_stb = fm_half;
        PATH_AM_SWAL: swal_stb = am_lo_i;
        default:      dir_stb  = am_lo_i;
      endcase
    end
  end

  dmd_swallow #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) u_swallow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (restart),
    .stb_i     (swal_stb),
    .main_ld_i (main_ld),
    .swal_ld_i (swal_ld),
    .done_o    (swal_done)
  );

  dmd_direct #(.W(DIR_W)) u_direct (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (restart),
    .stb_i  (dir_stb),
    .ld_i   (dir_ld),
    .done_o (dir_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= 1'b0;
    else         pulse_o <= swal_done || dir_done;
  end
endmodule

// File: rtl/dual_mode_divider_chk.sv
module dual_mode_divider_chk #(
  parameter int SWAL_W = 4,
  parameter int MAIN_W = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic am_lo_i,
  input logic fm_lo_i,
  input logic band_i,
  input logic swallow_i,
  input logic pulse_o
);
  localparam int CNT_W = SWAL_W + MAIN_W + 2;
  localparam logic [CNT_W-1:0] MIN_SW  = CNT_W'(1) << (2*SWAL_W);
  localparam logic [CNT_W-1:0] MIN_FM  = MIN_SW << 1;
  localparam logic [CNT_W-1:0] MIN_DIR = CNT_W'(4);

  logic [1:0]       path_now, path_q;
  logic             valid_q, stb_q, sel_stb;
  logic [CNT_W-1:0] cnt_q, min_n;

  assign path_now = band_i ? 2'd2 : (swallow_i ? 2'd1 : 2'd0);
  assign sel_stb  = band_i ? fm_lo_i : am_lo_i;
  assign min_n    = (path_q == 2'd2) ? MIN_FM : (path_q == 2'd1) ? MIN_SW : MIN_DIR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      path_q  <= 2'd0;
      stb_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_q <= 1'b1;
      path_q  <= path_now;
      stb_q   <= sel_stb;
      if (!valid_q || path_now != path_q) cnt_q <= '0;
      else if (pulse_o)                   cnt_q <= CNT_W'(sel_stb);
      else if (sel_stb && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  // R1
  pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && pulse_o) |-> stb_q);

  // R9
  mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && path_now != path_q) |=> !pulse_o);

  // R6
  min_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && pulse_o) |-> (cnt_q >= min_n));
endmodule

bind dual_mode_divider dual_mode_divider_chk #(.SWAL_W(SWAL_W), .MAIN_W(MAIN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .am_lo_i   (am_lo_i),
  .fm_lo_i   (fm_lo_i),
  .band_i    (band_i),
  .swallow_i (swallow_i),
  .pulse_o   (pulse_o)
);

// File: tb/dual_mode_divider_tb.sv
module dual_mode_divider_tb;
  localparam int CLK_P = 10;
  localparam int LIMIT = 140000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        am = 1'b0, fm = 1'b0, band = 1'b0, swal = 1'b0;
  logic [15:0] mod = 16'd4;
  logic        pulse;
  int          n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_mode_divider u_dut (
    .clk_i(clk), .rst_ni(rst_n), .am_lo_i(am), .fm_lo_i(fm),
    .band_i(band), .swallow_i(swal), .mod_i(mod), .pulse_o(pulse)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic restart(input logic b, input logic s, input logic [15:0] m);
    @(negedge clk);
    am = 0; fm = 0; band = b; swal = s; mod = m; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  // strobes held high; returns strobes until the next pulse
  task automatic period(output int n, input int chg_at, input logic [15:0] chg_val);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == chg_at) mod = chg_val;
    end while (!pulse && n < LIMIT);
  endtask

  task automatic meas(input logic b, input logic s, input logic [15:0] m,
                      input int exp, input int reps, input string tag);
    int n;
    restart(b, s, m);
    am = 1; fm = 1;
    for (int i = 0; i < reps; i++) begin
      period(n, -1, 16'd0);
      chk(n, exp, tag);
    end
    am = 0; fm = 0;
  endtask

  initial begin
    #(CLK_P * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n, hits;
    // reset state
    #(CLK_P * 2 + 1);
    chk(int'(pulse), 0, "R8 reset");

    // R3 direct sweep
    for (int k = 4; k <= 24; k++) meas(0, 0, 16'(k), k, 2, "R3 direct");
    meas(0, 0, 16'd4095, 4095, 1, "R3 direct max");
    meas(0, 0, 16'hF007, 7, 2, "R3 upper bits ignored");
    // R6 / R5 direct
    for (int k = 1; k <= 3; k++) meas(0, 0, 16'(k), 4, 2, "R6 direct clamp");
    meas(0, 0, 16'd0, 4096, 1, "R5 direct zero");

    // R2 AM swallow
    meas(0, 1, 16'd256, 256, 2, "R2 swallow");
    meas(0, 1, 16'd257, 257, 2, "R2 swallow");
    meas(0, 1, 16'd271, 271, 2, "R2 swallow");
    meas(0, 1, 16'd272, 272, 2, "R2 swallow");
    meas(0, 1, 16'd287, 287, 2, "R2 swallow");
    meas(0, 1, 16'd1000, 1000, 2, "R2 swallow");
    meas(0, 1, 16'd4111, 4111, 1, "R2 swallow");
    meas(0, 1, 16'd5, 256, 1, "R6 swallow clamp");
    meas(0, 1, 16'd255, 256, 1, "R6 swallow clamp");
    meas(0, 1, 16'd0, 65536, 1, "R5 swallow zero");

    // R4 FM
    meas(1, 1, 16'd256, 512, 2, "R4 fm");
    meas(1, 1, 16'd271, 542, 2, "R4 fm");
    meas(1, 1, 16'd1000, 2000, 1, "R4 fm");
    meas(1, 0, 16'd300, 600, 2, "R10 fm ignores structure");

    // R10 toggling structure bit mid-cycle in FM
    restart(1, 1, 16'd300);
    am = 1; fm = 1;
    period(n, -1, 16'd0);
    chk(n, 600, "R10 fm first");
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 100) swal = 0;
    end while (!pulse && n < LIMIT);
    chk(n, 600, "R10 toggle mid-cycle");

    // R7 modulus change mid-cycle
    restart(0, 0, 16'd10);
    am = 1; fm = 1;
    period(n, -1, 16'd0);
    chk(n, 10, "R7 before change");
    period(n, 3, 16'd6);
    chk(n, 10, "R7 current cycle kept");
    period(n, -1, 16'd0);
    chk(n, 6, "R7 new value applied");

    // R9 path change mid-cycle restarts
    restart(0, 0, 16'd7);
    am = 1; fm = 1;
    period(n, -1, 16'd0);
    chk(n, 7, "R9 before change");
    repeat (3) @(negedge clk);
    am = 0; fm = 0; band = 1; swal = 1; mod = 16'd300;
    @(negedge clk);
    chk(int'(pulse), 0, "R9 quiet after change");
    am = 1; fm = 1;
    period(n, -1, 16'd0);
    chk(n, 600, "R9 first cycle after change");

    // R1 unselected input ignored
    restart(0, 0, 16'd5);
    fm = 1; hits = 0;
    repeat (40) begin @(negedge clk); if (pulse) hits++; end
    chk(hits, 0, "R1 fm ignored in AM");
    am = 1;
    period(n, -1, 16'd0);
    chk(n, 5, "R1 am count untouched");
    restart(1, 1, 16'd256);
    am = 1; hits = 0;
    repeat (600) begin @(negedge clk); if (pulse) hits++; end
    chk(hits, 0, "R1 am ignored in FM");
    fm = 1;
    period(n, -1, 16'd0);
    chk(n, 512, "R1 fm count untouched");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule